// File: doc/BRIEF.md
# Mode-Switched 16-bit Signature Register

This block is a 16-bit register that sits beside the data-register path of a scan bridge and serves two purposes. When the current instruction selects it, it is a plain shift register in the active chain: feedback is cut, serial data enters at the MSB and leaves from the LSB. In this way a signature can be read out, or a seed loaded. When compaction is switched on and the register is not selected, it stays out of the chain. It watches the serial bit passing toward the test data output on every Shift-DR clock and folds that bit into a CRC-style signature. The scan bit itself goes through unchanged.

Compaction is switched on and off by one-cycle command pulses, which come from the instruction decoder after Update-IR. Switching compaction off freezes the signature. Outside Shift-DR the register never changes. The TAP controller and the instruction decoder are outside this block.

Top module: `sig_compactor`

## Requirements
- R1: After reset the signature is all zeros and compaction is off (`comp_on` = 0).
- R2: With `sel_chain` = 1, each clock with `shift_dr` = 1 shifts the register right: `scan_in` enters bit 15, and `scan_out` presents bit 0 during that cycle. No feedback is applied.
- R3: With `sel_chain` = 0 and compaction on, each clock with `shift_dr` = 1 updates the signature as follows. Let f = bit15 XOR `scan_in`. The new value is (old << 1) XOR (f ? 0x1021 : 0), which is the polynomial x^16 + x^12 + x^5 + 1.
- R4: Whenever `sel_chain` = 0, `scan_out` equals `scan_in` in the same cycle, whether compaction is on or off.
- R5: A `comp_stop` pulse turns compaction off. Afterwards Shift-DR clocks with `sel_chain` = 0 leave the signature unchanged.
- R6: While `shift_dr` = 0 the signature holds in every mode, whatever values `scan_in`, `sel_chain` or the commands take.
- R7: When the register is selected, it shifts as a plain register even if compaction is on. The compaction setting is kept, and compaction resumes once `sel_chain` drops.
- R8: A `comp_start` pulse turns compaction on from the next cycle. If `comp_start` and `comp_stop` arrive in the same cycle, compaction ends up off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| shift_dr | input | 1 | High while the TAP is in Shift-DR |
| sel_chain | input | 1 | Current instruction places this register in the scan chain |
| comp_start | input | 1 | One-cycle pulse that turns compaction on |
| comp_stop | input | 1 | One-cycle pulse that turns compaction off |
| scan_in | input | 1 | Serial scan data arriving from the active chain |
| scan_out | output | 1 | Serial data toward the test data output |
| comp_on | output | 1 | Compaction is currently on |

## Verification
On every cycle, the assertions check the following: holding outside Shift-DR, the frozen signature when compaction is off, the one-bit plain shift when selected, the feedback bit in compaction, and the precedence of the stop command. Whether a whole signature matches the polynomial over long streams can only be shown by the bench. The same holds for a loaded seed reading back intact, and for compaction resuming correctly after a select window. The bench does this by serial readout, comparing each bit against an arithmetic model.

// File: rtl/sig_compactor.sv
module sig_compactor #(
  parameter int W = 16,
  parameter logic [W-1:0] POLY = W'('h1021)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shift_dr,
  input  logic sel_chain,
  input  logic comp_start,
  input  logic comp_stop,
  input  logic scan_in,
  output logic scan_out,
  output logic comp_on
);

  logic [W-1:0] sig;
  logic         fb;

  assign fb       = sig[W-1] ^ scan_in;
  assign scan_out = sel_chain ? sig[0] : scan_in;

  always_ff @(posedge clk) begin
    if (!rst_n)          comp_on <= 1'b0;
    else if (comp_stop)  comp_on <= 1'b0;
    else if (comp_start) comp_on <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      sig <= '0;
    else if (shift_dr) begin
      if (sel_chain)
        sig <= {scan_in, sig[W-1:1]};
      else if (comp_on)
        sig <= {sig[W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
  end

endmodule

module sig_compactor_chk #(parameter int W = 16) (
  input logic         clk,
  input logic         rst_n,
  input logic         shift_dr,
  input logic         sel_chain,
  input logic         comp_start,
  input logic         comp_stop,
  input logic         scan_in,
  input logic         comp_on,
  input logic [W-1:0] sig
);

  assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_dr |=> $stable(sig));

  assert_frozen_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!comp_on && !sel_chain) |=> $stable(sig));

  assert_plain_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_dr && sel_chain) |=> (sig[W-2:0] == $past(sig[W-1:1])) && (sig[W-1] == $past(scan_in)));

  assert_feedback_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_dr && !sel_chain && comp_on) |=> sig[0] == ($past(sig[W-1]) ^ $past(scan_in)));

  assert_stop_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    comp_stop |=> !comp_on);

  assert_start_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(comp_on) |-> $past(comp_start));

endmodule

bind sig_compactor sig_compactor_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .shift_dr(shift_dr), .sel_chain(sel_chain),
  .comp_start(comp_start), .comp_stop(comp_stop), .scan_in(scan_in),
  .comp_on(comp_on), .sig(sig)
);

// File: tb/tb_sig_compactor.sv
module tb_sig_compactor;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic shift_dr = 1'b0, sel_chain = 1'b0, comp_start = 1'b0, comp_stop = 1'b0, scan_in = 1'b0;
  logic scan_out, comp_on;

  int vectors = 0;
  int errors  = 0;
  logic [15:0] m_sig;
  logic        m_on;

  always #5 clk = ~clk;

  sig_compactor dut (
    .clk(clk), .rst_n(rst_n), .shift_dr(shift_dr), .sel_chain(sel_chain),
    .comp_start(comp_start), .comp_stop(comp_stop), .scan_in(scan_in),
    .scan_out(scan_out), .comp_on(comp_on)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input string req, input logic sh, input logic sel,
                      input logic din, input logic st, input logic sp);
    logic [15:0] n;
    @(negedge clk);
    shift_dr = sh; sel_chain = sel; scan_in = din; comp_start = st; comp_stop = sp;
    #1;
    chk(sel ? req : "R4", scan_out, sel ? m_sig[0] : din);
    @(posedge clk);
    n = m_sig;
    if (sh) begin
      if (sel) n = {din, m_sig[15:1]};
      else if (m_on) n = {m_sig[14:0], 1'b0} ^ ((m_sig[15] ^ din) ? 16'h1021 : 16'h0);
    end
    m_sig = n;
    if (sp) m_on = 1'b0;
    else if (st) m_on = 1'b1;
    #1;
    chk(st || sp ? "R8" : req, comp_on, m_on);
  endtask

  task automatic readout(input string req);
    for (int i = 0; i < 16; i++) step(req, 1'b1, 1'b1, 1'($urandom), 1'b0, 1'b0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    m_sig = 16'h0; m_on = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1 chk("R1", comp_on, 1'b0);
    for (int i = 0; i < 16; i++) step("R1", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);

    for (int it = 0; it < 8; it++) begin
      for (int i = 0; i < 16; i++) step("R2", 1'b1, 1'b1, 1'($urandom), 1'b0, 1'b0);
      readout("R2");
      step("R8", 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
      for (int i = 0; i < 40 + it; i++) step("R3", 1'b1, 1'b0, 1'($urandom), 1'b0, 1'b0);
      for (int i = 0; i < 10; i++)
        step("R6", 1'b0, 1'($urandom), 1'($urandom), 1'b0, 1'b0);
      for (int i = 0; i < 5; i++) step("R7", 1'b1, 1'b1, 1'($urandom), 1'b0, 1'b0);
      for (int i = 0; i < 20; i++) step("R7", 1'b1, 1'b0, 1'($urandom), 1'b0, 1'b0);
      readout("R3");
      step("R5", 1'b1, 1'b0, 1'($urandom), 1'b0, 1'b1);
      for (int i = 0; i < 20; i++) step("R5", 1'b1, 1'b0, 1'($urandom), 1'b0, 1'b0);
      readout("R5");
      step("R8", 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
      for (int i = 0; i < 8; i++) step("R8", 1'b1, 1'b0, 1'($urandom), 1'b0, 1'b0);
      readout("R8");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule